// File: doc/BRIEF.md
# Scope Trace Raster Comparator

This block turns two stored sample records into per-pixel trace marks for an oscilloscope-style raster display. While the video timing walks the screen, the block drives the current pixel column as the read address of two external sample memories, a left one and a right one, with the read strobe permanently on. One clock later each memory returns a 16-bit unsigned sample word. The block keeps only the ten most significant bits as a vertical position and shifts it down by a fixed row offset so that the mid-scale code lands on the centre row of the grid.

The shifted value is compared with the row of the same pixel, which is delayed one clock to line up with the returned data. A channel mark is raised when the two are equal, when the pixel lies inside the trace area and when that channel's enable bit is set. Marks for both channels are registered, so a pixel presented in cycle N produces its marks in cycle N+2. The display mixer downstream decides colours and draws the grid; video timing is produced elsewhere.

Top module: `scope_trace_raster`

## Requirements
- R1: `mem_rd_en` is 1 in every cycle and `mem_rd_addr` equals `pix_col` in the same cycle.
- R2: The vertical position of a sample is its bits [15:6]; bits [5:0] of the word have no effect on the marks.
- R3: A position field F maps to screen row F − 292, so field 512 (word 16'h8000) maps to row 220.
- R4: `hit_ch1` is 1 two clocks after a pixel is presented exactly when the left word read for that pixel's column maps to that pixel's row and the pixel passes the gates of R6, R7 and R8.
- R5: `hit_ch2` behaves as in R4 using the right word.
- R6: `trace_en[0]` gates channel 1 and `trace_en[1]` gates channel 2; each bit is taken together with the pixel it applies to.
- R7: A field below 292 or above 771 (mapped row outside 0..479) never produces a mark, whatever the row.
- R8: Only columns 20 to 659 inclusive can produce a mark.
- R9: A synchronous active-high `rst` clears both marks and any pixel in flight; marks are 0 in the cycle after reset is seen.
- R10: The two channels are judged independently, so both marks can be 1 for the same pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_col | input | 10 | Current video column |
| pix_row | input | 10 | Current video row |
| trace_en | input | 2 | Bit 0 enables channel 1, bit 1 enables channel 2 |
| mem_rd_addr | output | 10 | Read address to both sample memories |
| mem_rd_en | output | 1 | Read strobe to both sample memories |
| left_word | input | 16 | Left memory data, valid one clock after the address |
| right_word | input | 16 | Right memory data, valid one clock after the address |
| hit_ch1 | output | 1 | Channel 1 trace mark for the pixel presented two clocks earlier |
| hit_ch2 | output | 1 | Channel 2 trace mark for the pixel presented two clocks earlier |

## Verification
Both channel comparisons fall in the same cycle, and a correct result for one must not disturb the other. This is provoked by loading the same mid-scale word into both memories at one column and scanning the rows around 220, then by enabling only one channel at a time at that pixel. Each pixel's pair of expected marks is derived from the stored words and the requirement rules and compared two clocks later against both outputs together, so a swapped, shared or mis-gated channel shows as a mismatch on a single bit.

// File: rtl/scope_trace_pkg.sv
package scope_trace_pkg;

  // Default geometry and sample format of the scope trace path.
  localparam int unsigned DEF_COORD_W    = 10;
  localparam int unsigned DEF_WORD_W     = 16;
  localparam int unsigned DEF_FIELD_W    = 10;
  localparam int unsigned DEF_ROW_OFFSET = 292;
  localparam int unsigned DEF_ROWS       = 480;
  localparam int unsigned DEF_COL_FIRST  = 20;
  localparam int unsigned DEF_COL_SPAN   = 640;

  // Pixel context carried alongside the one-cycle memory read.
  typedef struct packed {
    logic col_ok;
    logic [1:0] en;
  } px_ctx_t;

endpackage

// File: rtl/trace_addr_gen.sv
module trace_addr_gen
  import scope_trace_pkg::*;
#(
  parameter int unsigned COORD_W   = DEF_COORD_W,
  parameter int unsigned COL_FIRST = DEF_COL_FIRST,
  parameter int unsigned COL_SPAN  = DEF_COL_SPAN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] pix_col,
  input  logic [COORD_W-1:0] pix_row,
  input  logic [1:0]         trace_en,
  output logic [COORD_W-1:0] rd_addr,
  output logic               rd_en,
  output logic [COORD_W-1:0] row_d,
  output px_ctx_t            ctx_d
);

  localparam int unsigned COL_END = COL_FIRST + COL_SPAN;
  localparam logic [COORD_W:0] COL_LO = COL_FIRST[COORD_W:0];
  localparam logic [COORD_W:0] COL_HI = COL_END[COORD_W:0];

  logic    col_ok;
  px_ctx_t ctx_now;

  // Address follows the column directly; the memory registers it.
  assign rd_addr = pix_col;
  assign rd_en   = 1'b1;

  assign col_ok = ({1'b0, pix_col} >= COL_LO) && ({1'b0, pix_col} < COL_HI);

  always_comb begin
    ctx_now.col_ok = col_ok;
    ctx_now.en     = trace_en;
  end

  // Row and gates travel one stage to meet the returned sample.
  always_ff @(posedge clk) begin
    if (rst) begin
      row_d <= '0;
      ctx_d <= '0;
    end else begin
      row_d <= pix_row;
      ctx_d <= ctx_now;
    end
  end

endmodule

// File: rtl/trace_row_map.sv
module trace_row_map
  import scope_trace_pkg::*;
#(
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned FIELD_W    = DEF_FIELD_W,
  parameter int unsigned COORD_W    = DEF_COORD_W,
  parameter int unsigned ROW_OFFSET = DEF_ROW_OFFSET,
  parameter int unsigned ROWS       = DEF_ROWS
) (
  input  logic [WORD_W-1:0]  word,
  output logic [COORD_W-1:0] row,
  output logic               row_ok
);

  localparam int unsigned DROP_W = WORD_W - FIELD_W;
  localparam logic [FIELD_W:0] OFF_V  = ROW_OFFSET[FIELD_W:0];
  localparam logic [FIELD_W:0] ROWS_V = ROWS[FIELD_W:0];

  logic [FIELD_W-1:0] field;
  logic [FIELD_W:0]   diff;
  logic               unused_low;

  assign field      = word[WORD_W-1 -: FIELD_W];
  assign unused_low = &{1'b0, word[DROP_W-1:0]};

  assign diff   = {1'b0, field} - OFF_V;
  assign row_ok = ({1'b0, field} >= OFF_V) && (diff < ROWS_V);
  assign row    = COORD_W'(diff);

endmodule

// File: rtl/trace_hit_cmp.sv
module trace_hit_cmp #(
  parameter int unsigned COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] trace_row,
  input  logic               trace_ok,
  input  logic [COORD_W-1:0] scan_row,
  input  logic               col_ok,
  input  logic               chan_en,
  output logic               hit
);

  logic hit_n;

  assign hit_n = trace_ok && col_ok && chan_en && (trace_row == scan_row);

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= hit_n;
  end

  // R6
  gate_seen_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(chan_en));

endmodule

// File: rtl/scope_trace_raster.sv
module scope_trace_raster
  import scope_trace_pkg::*;
#(
  parameter int unsigned COORD_W    = DEF_COORD_W,
  parameter int unsigned WORD_W     = DEF_WORD_W,
  parameter int unsigned FIELD_W    = DEF_FIELD_W,
  parameter int unsigned ROW_OFFSET = DEF_ROW_OFFSET,
  parameter int unsigned ROWS       = DEF_ROWS,
  parameter int unsigned COL_FIRST  = DEF_COL_FIRST,
  parameter int unsigned COL_SPAN   = DEF_COL_SPAN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [COORD_W-1:0] pix_col,
  input  logic [COORD_W-1:0] pix_row,
  input  logic [1:0]         trace_en,
  output logic [COORD_W-1:0] mem_rd_addr,
  output logic               mem_rd_en,
  input  logic [WORD_W-1:0]  left_word,
  input  logic [WORD_W-1:0]  right_word,
  output logic               hit_ch1,
  output logic               hit_ch2
);

  localparam int unsigned NUM_CH  = 2;
  localparam int unsigned COL_END = COL_FIRST + COL_SPAN;
  localparam int unsigned FIELD_MAX = ROW_OFFSET + ROWS - 1;

  logic [COORD_W-1:0] row_d;
  px_ctx_t            ctx_d;
  logic [WORD_W-1:0]  words [NUM_CH];
  logic [NUM_CH-1:0]  hits;

  assign words[0] = left_word;
  assign words[1] = right_word;

  trace_addr_gen #(
    .COORD_W  (COORD_W),
    .COL_FIRST(COL_FIRST),
    .COL_SPAN (COL_SPAN)
  ) addr_i (
    .clk     (clk),
    .rst     (rst),
    .pix_col (pix_col),
    .pix_row (pix_row),
    .trace_en(trace_en),
    .rd_addr (mem_rd_addr),
    .rd_en   (mem_rd_en),
    .row_d   (row_d),
    .ctx_d   (ctx_d)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [COORD_W-1:0] map_row;
    logic               map_ok;

    trace_row_map #(
      .WORD_W    (WORD_W),
      .FIELD_W   (FIELD_W),
      .COORD_W   (COORD_W),
      .ROW_OFFSET(ROW_OFFSET),
      .ROWS      (ROWS)
    ) map_i (
      .word  (words[ch]),
      .row   (map_row),
      .row_ok(map_ok)
    );

    trace_hit_cmp #(
      .COORD_W(COORD_W)
    ) cmp_i (
      .clk      (clk),
      .rst      (rst),
      .trace_row(map_row),
      .trace_ok (map_ok),
      .scan_row (row_d),
      .col_ok   (ctx_d.col_ok),
      .chan_en  (ctx_d.en[ch]),
      .hit      (hits[ch])
    );
  end

  assign hit_ch1 = hits[0];
  assign hit_ch2 = hits[1];

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!hit_ch1 && !hit_ch2));

  // R8
  col_window_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_ch1 || hit_ch2) |->
      (($past(pix_col, 2) >= COORD_W'(COL_FIRST)) &&
       ({1'b0, $past(pix_col, 2)} < (COORD_W+1)'(COL_END))));

  // R6
  en_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_ch1 |-> $past(trace_en[0], 2)) and (hit_ch2 |-> $past(trace_en[1], 2)));

  // R7
  field_range_chk: assert property (@(posedge clk) disable iff (rst)
    hit_ch1 |-> (($past(left_word[WORD_W-1 -: FIELD_W]) >= FIELD_W'(ROW_OFFSET)) &&
                 ($past(left_word[WORD_W-1 -: FIELD_W]) <= FIELD_W'(FIELD_MAX))));

  // R4
  row_match_chk: assert property (@(posedge clk) disable iff (rst)
    hit_ch1 |-> (COORD_W'($past(left_word[WORD_W-1 -: FIELD_W]) - FIELD_W'(ROW_OFFSET))
                 == $past(pix_row, 2)));

endmodule

// File: tb/scope_trace_raster_tb.sv
module scope_trace_raster_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  pix_col, pix_row;
  logic [1:0]  trace_en;
  logic [9:0]  mem_rd_addr;
  logic        mem_rd_en;
  logic [15:0] left_word, right_word;
  logic        hit_ch1, hit_ch2;

  always #(CLK_PERIOD/2) clk = ~clk;

  scope_trace_raster dut_i (
    .clk(clk), .rst(rst), .pix_col(pix_col), .pix_row(pix_row),
    .trace_en(trace_en), .mem_rd_addr(mem_rd_addr), .mem_rd_en(mem_rd_en),
    .left_word(left_word), .right_word(right_word),
    .hit_ch1(hit_ch1), .hit_ch2(hit_ch2)
  );

  // Sample memories: registered read, one clock of latency.
  logic [15:0] lmem [0:1023];
  logic [15:0] rmem [0:1023];
  always_ff @(posedge clk) begin
    if (mem_rd_en) begin
      left_word  <= lmem[mem_rd_addr];
      right_word <= rmem[mem_rd_addr];
    end
  end

  typedef struct {
    int    due;
    logic  e1;
    logic  e2;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] word_for_row(int r, int junk);
    return 16'(((r + 292) << 6) | (junk & 63));
  endfunction

  function automatic logic exp_hit(logic [15:0] w, int col, int row, logic en);
    int f;
    f = int'(w[15:6]);
    if (!en) return 1'b0;
    if (col < 20 || col > 659) return 1'b0;
    if (f < 292 || f > 771) return 1'b0;
    return (f - 292) == row;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic drive_px(int col, int row, logic [1:0] en, string tag);
    exp_t e;
    @(negedge clk);
    pix_col  = 10'(col);
    pix_row  = 10'(row);
    trace_en = en;
    e.due = cyc + 2;
    e.e1  = exp_hit(lmem[col], col, row, en[0]);
    e.e2  = exp_hit(rmem[col], col, row, en[1]);
    e.tag = tag;
    q.push_back(e);
    #1;
    check(mem_rd_addr == 10'(col) && mem_rd_en == 1'b1, "R1", "read address/enable",
          int'({mem_rd_en, mem_rd_addr}), int'({1'b1, 10'(col)}));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive_px(0, 0, 2'b00, "R8 idle");
  endtask

  // Monitor: compares each pixel's marks two clocks after it was driven.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        e = q.pop_front();
        check(e.due == cyc && hit_ch1 == e.e1 && hit_ch2 == e.e2, e.tag, "marks {ch2,ch1}",
              int'({hit_ch2, hit_ch1}), int'({e.e2, e.e1}));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 1024; a++) begin
      lmem[a] = word_for_row((a * 7) % 480, a);
      rmem[a] = word_for_row((a * 13 + 100) % 480, a * 3);
    end
    // Mid-scale at both channels (R3, R10)
    lmem[100] = 16'h8000;
    rmem[100] = 16'h8000;
    // Low-bit independence (R2): 512 with junk, 511 with junk
    lmem[101] = 16'h803F;
    rmem[101] = 16'h7FFF;
    // Out-of-range fields (R7)
    lmem[110] = 16'(291 << 6);
    rmem[110] = 16'(772 << 6);
    // Range edges (R7)
    lmem[111] = 16'(292 << 6);
    rmem[111] = 16'(771 << 6);
    // Column window edges (R8)
    lmem[19]  = 16'h8000; rmem[19]  = 16'h8000;
    lmem[20]  = 16'h8000; rmem[20]  = 16'h8000;
    lmem[659] = 16'h8000; rmem[659] = 16'h8000;
    lmem[660] = 16'h8000; rmem[660] = 16'h8000;

    rst = 1'b1; pix_col = '0; pix_row = '0; trace_en = 2'b11;
    repeat (3) @(negedge clk);
    #1;
    check(!hit_ch1 && !hit_ch2, "R9", "reset state", int'({hit_ch2, hit_ch1}), 0);
    @(negedge clk);
    rst = 1'b0;

    // R4 R5: scan columns with rows around each channel's mapped row
    for (int c = 30; c < 37; c++) begin
      int lr, rr;
      lr = (c * 7) % 480;
      rr = (c * 13 + 100) % 480;
      drive_px(c, lr - 1, 2'b11, "R4 scan");
      drive_px(c, lr,     2'b11, "R4 scan");
      drive_px(c, lr + 1, 2'b11, "R4 scan");
      drive_px(c, rr,     2'b11, "R5 scan");
      drive_px(c, rr + 1, 2'b11, "R5 scan");
    end

    // R3 R10: mid-scale maps to row 220 on both channels together
    drive_px(100, 219, 2'b11, "R3 row 219");
    drive_px(100, 220, 2'b11, "R10 both at 220");
    drive_px(100, 221, 2'b11, "R3 row 221");

    // R2: low six bits do not move the trace
    drive_px(101, 219, 2'b11, "R2 row 219");
    drive_px(101, 220, 2'b11, "R2 row 220");

    // R7: fields outside 292..771 never mark; edges do
    drive_px(110, 1023, 2'b11, "R7 below range");
    drive_px(110, 480,  2'b11, "R7 above range");
    drive_px(111, 0,    2'b11, "R7 row 0 edge");
    drive_px(111, 479,  2'b11, "R7 row 479 edge");

    // R8: column window
    drive_px(19,  220, 2'b11, "R8 col 19");
    drive_px(20,  220, 2'b11, "R8 col 20");
    drive_px(659, 220, 2'b11, "R8 col 659");
    drive_px(660, 220, 2'b11, "R8 col 660");

    // R6: per-channel enables
    drive_px(100, 220, 2'b00, "R6 none");
    drive_px(100, 220, 2'b01, "R6 ch1 only");
    drive_px(100, 220, 2'b10, "R6 ch2 only");
    drive_px(100, 220, 2'b11, "R6 both");
    idle(3);

    // R9: reset while a mark is in flight
    drive_px(100, 220, 2'b11, "R9 pre");
    @(negedge clk);
    q.delete();
    rst = 1'b1;
    @(negedge clk);
    #1;
    check(!hit_ch1 && !hit_ch2, "R9", "flush in flight", int'({hit_ch2, hit_ch1}), 0);
    rst = 1'b0;
    idle(3);
    drive_px(100, 220, 2'b11, "R9 after reset");
    idle(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule